// File: doc/BRIEF.md
# Resistive Panel Switch and Pen-Detect Controller

This block sits between the control-word latch and conversion sequencer of a touch-panel converter and the analog switch matrix. It turns the latched channel code, reference-mode bit and power-down code into enables for the four panel corner switches. It also produces the converter input select and the reference select. These are timed against the acquire, convert and idle phase flags that the sequencer reports.

While the converter is idle in the power-down mode that allows pen interrupts, the block grounds the lower-right corner. It routes the wiper onto the pen-sense path and drives an active-low pen interrupt from the touch-sense input. When the pen-detect channel is selected under chip select, the block raises a flag that tells the serial output stage to send a constant word. That word is all ones when the panel is touched and all zeros when it is not.

With the always-powered code, the block keeps the last measurement's drivers on after the phase ends. They stay on until a control field changes or chip select is released. The internal state is one hold flag and a copy of the fields that set it. Every output is a combinational function of the present inputs and that state.

Top module: `panel_switch_ctrl`

## Requirements
- R1: Channel code 3'b001 (Y measurement), while its drivers are active, drives upper-left and upper-right to supply and lower-left and lower-right to ground.
- R2: Channel code 3'b101 (X measurement), while its drivers are active, drives upper-left and lower-left to supply and upper-right and lower-right to ground.
- R3: Channel codes other than 3'b001 and 3'b101 turn on no supply or measurement driver. `adc_in_aux` is 1 only for code 3'b010.
- R4: With `ref_single`=1 the measurement drivers are on only while `ph_acq` is high. They are off during `ph_conv` unless the R6 hold applies, and `ref_from_panel` is 0.
- R5: With `ref_single`=0 and an X or Y channel, the drivers stay on through both `ph_acq` and `ph_conv`, and `ref_from_panel` is 1.
- R6: With power-down code 2'b11, once an X or Y channel's drivers have been active while `cs_n` is low, they stay on after the phase ends. They drop in the same cycle in which the channel, reference mode or power-down field differs from the values that set the hold, or in which `cs_n` is high.
- R7: With power-down code 2'b00 and both phase flags low, `lr_gnd` and `pen_path_en` are 1 and `pen_irq_n` equals the inverse of `touch`.
- R8: Power-down codes 2'b01 and 2'b10 keep `pen_irq_n` at 1 and leave `lr_gnd` and `pen_path_en` at 0 while idle.
- R9: While `ph_acq` or `ph_conv` is high, `pen_irq_n` is 1 and `pen_path_en` is 0, whatever `touch` is.
- R10: `pdet_force` is 1 exactly when the channel is 3'b110, the power-down code is 2'b00 and `cs_n` is low. `pdet_level` then equals `touch` and is 0 otherwise.
- R11: After reset, with no phase active, no driver is on even under power-down code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan | input | 3 | Latched channel code |
| ref_single | input | 1 | 1: reference from reference pin and ground; 0: ratiometric |
| pd_mode | input | 2 | Latched power-down code |
| ph_acq | input | 1 | Sequencer reports acquisition |
| ph_conv | input | 1 | Sequencer reports conversion |
| cs_n | input | 1 | Chip select, active low |
| touch | input | 1 | Touch-sense comparator, 1 when the panel is pressed |
| ul_vcc | output | 1 | Upper-left corner to supply |
| ur_vcc | output | 1 | Upper-right corner to supply |
| ur_gnd | output | 1 | Upper-right corner to ground |
| ll_vcc | output | 1 | Lower-left corner to supply |
| ll_gnd | output | 1 | Lower-left corner to ground |
| lr_gnd | output | 1 | Lower-right corner to ground |
| adc_in_aux | output | 1 | Converter input from auxiliary pin (0: wiper) |
| ref_from_panel | output | 1 | Converter reference from active panel corners |
| pen_path_en | output | 1 | Wiper connected to pen-sense path |
| pen_irq_n | output | 1 | Pen interrupt, active low |
| pdet_force | output | 1 | Serial output sends the constant pen-detect word |
| pdet_level | output | 1 | Bit value of the constant pen-detect word |

## Verification
Every output is due in the same cycle as the inputs that decide it, with one exception: the R6 hold is taken at the clock edge that ends an active cycle and takes effect from the next cycle. Its release is immediate, in the cycle the fields change or `cs_n` rises. Stimulus is applied on the falling edge and the outputs are sampled shortly before the next rising edge. Each expected value therefore reflects hold state from edges that have already passed, never from the edge being approached. Hold sequences are one-cycle-per-step chains, so the set, carry, release and no-reassert cycles each have their own check.

// File: rtl/panel_switch_ctrl.sv
module panel_switch_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] chan,
  input  logic       ref_single,
  input  logic [1:0] pd_mode,
  input  logic       ph_acq,
  input  logic       ph_conv,
  input  logic       cs_n,
  input  logic       touch,
  output logic       ul_vcc,
  output logic       ur_vcc,
  output logic       ur_gnd,
  output logic       ll_vcc,
  output logic       ll_gnd,
  output logic       lr_gnd,
  output logic       adc_in_aux,
  output logic       ref_from_panel,
  output logic       pen_path_en,
  output logic       pen_irq_n,
  output logic       pdet_force,
  output logic       pdet_level
);

  localparam logic [2:0] CH_Y   = 3'b001;
  localparam logic [2:0] CH_X   = 3'b101;
  localparam logic [2:0] CH_AUX = 3'b010;
  localparam logic [2:0] CH_PEN = 3'b110;
  localparam logic [1:0] PD_AUTO_IRQ = 2'b00;
  localparam logic [1:0] PD_ALWAYS   = 2'b11;

  logic       is_y, is_x, is_meas, idle, pd_irq, pd_on;
  logic       active_now, hold_q, hold_eff, drive;
  logic [5:0] fields, snap_q;

  assign is_y    = (chan == CH_Y);
  assign is_x    = (chan == CH_X);
  assign is_meas = is_y | is_x;
  assign idle    = ~ph_acq & ~ph_conv;
  assign pd_irq  = (pd_mode == PD_AUTO_IRQ);
  assign pd_on   = (pd_mode == PD_ALWAYS);
  assign fields  = {chan, ref_single, pd_mode};

  assign active_now = is_meas & (ph_acq | (ph_conv & ~ref_single));
  assign hold_eff   = hold_q & ~cs_n & (fields == snap_q);
  assign drive      = active_now | hold_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      snap_q <= '0;
    end else begin
      hold_q <= (active_now & pd_on & ~cs_n) | hold_eff;
      if (active_now) snap_q <= fields;
    end
  end

  assign ul_vcc = drive;
  assign ur_vcc = drive & is_y;
  assign ur_gnd = drive & is_x;
  assign ll_vcc = drive & is_x;
  assign ll_gnd = drive & is_y;
  assign lr_gnd = drive | (idle & pd_irq);

  assign adc_in_aux     = (chan == CH_AUX);
  assign ref_from_panel = is_meas & ~ref_single;

  assign pen_path_en = idle & pd_irq;
  assign pen_irq_n   = ~(pen_path_en & touch);

  assign pdet_force = (chan == CH_PEN) & pd_irq & ~cs_n;
  assign pdet_level = pdet_force & touch;

  assert_ratio_conv_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_conv && !ref_single && chan == CH_Y) |-> (ur_vcc && ll_gnd && ref_from_panel));

  assert_se_conv_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_conv && !ph_acq && ref_single && pd_mode != PD_ALWAYS) |-> !(ul_vcc || ur_vcc || ll_vcc || ll_gnd));

  assert_irq_idle_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pen_irq_n |-> (!ph_acq && !ph_conv && touch));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode != PD_AUTO_IRQ) |-> (pen_irq_n && !pen_path_en));

  assert_cs_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !ph_acq && !ph_conv) |-> !(ul_vcc || ur_vcc || ll_vcc));

  assert_hold_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_acq && chan == CH_Y && pd_mode == PD_ALWAYS && !cs_n)
     && !ph_acq && !ph_conv && !cs_n && $stable(chan) && $stable(ref_single)
     && $stable(pd_mode)) |-> (ul_vcc && ur_vcc && ll_gnd));

endmodule

// File: tb/panel_switch_ctrl_tb.sv
module panel_switch_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] chan = 3'b000;
  logic       ref_single = 1'b1;
  logic [1:0] pd_mode = 2'b11;
  logic       ph_acq = 1'b0;
  logic       ph_conv = 1'b0;
  logic       cs_n = 1'b0;
  logic       touch = 1'b0;
  logic ul_vcc, ur_vcc, ur_gnd, ll_vcc, ll_gnd, lr_gnd;
  logic adc_in_aux, ref_from_panel, pen_path_en, pen_irq_n, pdet_force, pdet_level;

  int errors = 0;
  int checks = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  panel_switch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .chan(chan), .ref_single(ref_single),
    .pd_mode(pd_mode), .ph_acq(ph_acq), .ph_conv(ph_conv), .cs_n(cs_n),
    .touch(touch), .ul_vcc(ul_vcc), .ur_vcc(ur_vcc), .ur_gnd(ur_gnd),
    .ll_vcc(ll_vcc), .ll_gnd(ll_gnd), .lr_gnd(lr_gnd), .adc_in_aux(adc_in_aux),
    .ref_from_panel(ref_from_panel), .pen_path_en(pen_path_en),
    .pen_irq_n(pen_irq_n), .pdet_force(pdet_force), .pdet_level(pdet_level)
  );

  // vector: {ul,urv,urg,llv,llg,lr, aux,refp, pen,irq_n, force,level}
  task automatic step(input logic [2:0] c, input logic se, input logic [1:0] pd,
                      input logic acq, input logic conv, input logic csn,
                      input logic t, input logic [11:0] exp, input string tag);
    @(negedge clk);
    chan = c; ref_single = se; pd_mode = pd;
    ph_acq = acq; ph_conv = conv; cs_n = csn; touch = t;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() != 0) begin
        logic [11:0] e, a;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        a  = {ul_vcc, ur_vcc, ur_gnd, ll_vcc, ll_gnd, lr_gnd,
              adc_in_aux, ref_from_panel, pen_path_en, pen_irq_n, pdet_force, pdet_level};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: got %b expected %b", tg, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(3'b001, 1, 2'b11, 0, 0, 0, 1, 12'b000000_00_01_00, "R11 reset idle");
    step(3'b001, 1, 2'b00, 1, 0, 0, 1, 12'b110011_00_01_00, "R1 Y acquire, R9 irq masked");
    step(3'b001, 1, 2'b00, 0, 1, 0, 1, 12'b000000_00_01_00, "R4 single-ended convert off");
    step(3'b001, 1, 2'b00, 0, 0, 0, 1, 12'b000001_00_10_00, "R7 idle touched");
    step(3'b001, 1, 2'b00, 0, 0, 0, 0, 12'b000001_00_11_00, "R7 idle untouched");
    step(3'b101, 0, 2'b01, 1, 0, 0, 0, 12'b101101_01_01_00, "R2 X acquire ratiometric");
    step(3'b101, 0, 2'b01, 0, 1, 0, 1, 12'b101101_01_01_00, "R5 ratiometric convert on, R9");
    step(3'b101, 0, 2'b01, 0, 0, 0, 1, 12'b000000_01_01_00, "R8 code 01 idle");
    step(3'b101, 0, 2'b10, 0, 0, 0, 1, 12'b000000_01_01_00, "R8 reserved code 10 idle");
    step(3'b010, 1, 2'b11, 1, 0, 0, 0, 12'b000000_10_01_00, "R3 aux channel");
    step(3'b110, 1, 2'b00, 0, 0, 0, 1, 12'b000001_00_10_11, "R10 pen detect touched");
    step(3'b110, 1, 2'b00, 0, 0, 0, 0, 12'b000001_00_11_10, "R10 pen detect untouched");
    step(3'b110, 1, 2'b00, 0, 0, 1, 1, 12'b000001_00_10_00, "R10 pen detect deselected");
    step(3'b110, 1, 2'b11, 1, 0, 0, 1, 12'b000000_00_01_00, "R3 pen channel no drivers");
    step(3'b001, 1, 2'b11, 1, 0, 0, 0, 12'b110011_00_01_00, "R6 hold set acquire");
    step(3'b001, 1, 2'b11, 0, 1, 0, 0, 12'b110011_00_01_00, "R6 hold through convert");
    step(3'b001, 1, 2'b11, 0, 0, 0, 0, 12'b110011_00_01_00, "R6 hold idle 1");
    step(3'b001, 1, 2'b11, 0, 0, 0, 0, 12'b110011_00_01_00, "R6 hold idle 2");
    step(3'b101, 1, 2'b11, 0, 0, 0, 0, 12'b000000_00_01_00, "R6 channel change drops");
    step(3'b001, 1, 2'b11, 0, 0, 0, 0, 12'b000000_00_01_00, "R6 no reassert");
    step(3'b001, 0, 2'b11, 1, 0, 0, 0, 12'b110011_01_01_00, "R6 hold set ratiometric");
    step(3'b001, 0, 2'b11, 0, 0, 1, 0, 12'b000000_01_01_00, "R6 cs high drops");
    step(3'b001, 0, 2'b11, 0, 0, 0, 0, 12'b000000_01_01_00, "R6 cs low stays off");
    step(3'b001, 1, 2'b11, 1, 0, 0, 0, 12'b110011_00_01_00, "R6 hold set again");
    step(3'b001, 1, 2'b01, 0, 0, 0, 0, 12'b000000_00_01_00, "R6 power-down change drops");
    step(3'b101, 1, 2'b11, 1, 0, 0, 0, 12'b101101_00_01_00, "R2 X single-ended acquire");
    step(3'b101, 0, 2'b11, 0, 0, 0, 0, 12'b000000_01_01_00, "R6 reference change drops");
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule